// File: doc/BRIEF.md
# Vector Lane Widening Extend Unit

This datapath block serves a 256-bit SIMD register file. It takes one source vector and a 5-bit minor opcode. It produces a full-width destination vector whose lanes are wider than the source elements. Each destination lane is filled from the source element with the same index, so only the lowest-numbered source elements are consumed. The opcode chooses the width pair and chooses between two's-complement (sign) extension and zero extension.

Six width pairs are supported, each in a signed and an unsigned flavour: byte to halfword, word or doubleword; halfword to word or doubleword; and word to doubleword. The whole result is formed before it reaches the output. A destination that names the same register as the source therefore still sees the original source values. Opcodes outside the map raise an illegal flag and force the destination to zero. A parameter chooses between a purely combinational path and a registered path with a valid strobe and one cycle of latency; the default is registered.

Top module: `vec_widen_unit`

## Requirements
- R1: Opcodes 4, 5, 6, 7, 8, 9 select signed widening of byte→halfword, byte→word, byte→doubleword, halfword→word, halfword→doubleword and word→doubleword, in that order.
- R2: Opcodes 10 to 15 select the same six width pairs in the same order, with zero extension.
- R3: Lanes are little-endian: destination lane i occupies bits [i*D +: D], where D is the destination width. Lane i is taken from source bits [i*S +: S], where S is the source width. There are 256/D lanes.
- R4: In the signed modes, every bit of a lane above the source width equals bit S-1 of its source element.
- R5: In the unsigned modes, every bit of a lane above the source width is zero.
- R6: Source bits at or above (256/D)*S have no effect on the result.
- R7: Opcodes 0 to 3 and 16 to 31 drive `op_illegal` high and the whole destination to zero.
- R8: Opcodes 4 to 15 drive `op_illegal` low.
- R9: In registered mode (REGISTERED=1), a request accepted with `in_valid` high appears on `dst_vec` and `op_illegal` one clock later, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next clock, and `dst_vec` and `op_illegal` keep their values.
- R10: While `rst_n` is low, `out_valid`, `op_illegal` and `dst_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for the current opcode and source |
| op_code | input | 5 | Minor opcode selecting the width pair and the signedness |
| src_vec | input | 256 | Source vector |
| out_valid | output | 1 | Result strobe |
| dst_vec | output | 256 | Widened destination vector |
| op_illegal | output | 1 | High when the opcode is outside the supported map |

## Verification
Every one of the 32 opcodes is applied to several kinds of source vector. Bytes of 0x80 and 0x7F, halfwords of 0x8000 and words of 0x80000000 place a set or clear top bit exactly at each source width. These vectors separate sign fill from zero fill, and they expose a source width that is off by one element size. Random vectors catch lane misplacement and swapped pairs in the opcode map. A second source that differs only in its upper, unused elements must give an identical result. Idle cycles between requests show that the output holds its value and that the strobe drops.

// File: rtl/vwx_pkg.sv
package vwx_pkg;

  localparam int unsigned NUM_PAIRS = 6;
  localparam logic [4:0]  OP_SGN_FIRST = 5'd4;
  localparam logic [4:0]  OP_SGN_LAST  = 5'd9;
  localparam logic [4:0]  OP_UNS_FIRST = 5'd10;
  localparam logic [4:0]  OP_UNS_LAST  = 5'd15;

  typedef struct packed {
    logic       legal;
    logic       sext;
    logic [2:0] pair;
  } vwx_dec_t;

  // Source element width of a width pair (index order follows opcode order).
  function automatic int unsigned pair_src_bits(input int unsigned p);
    case (p)
      0, 1, 2: return 8;
      3, 4:    return 16;
      default: return 32;
    endcase
  endfunction

  // Destination lane width of a width pair.
  function automatic int unsigned pair_dst_bits(input int unsigned p);
    case (p)
      0:       return 16;
      1, 3:    return 32;
      default: return 64;
    endcase
  endfunction

  // Opcode decode: legal flag, signedness and pair index.
  function automatic vwx_dec_t decode_op(input logic [4:0] op);
    vwx_dec_t d;
    d = '0;
    if (op >= OP_SGN_FIRST && op <= OP_SGN_LAST) begin
      d.legal = 1'b1;
      d.sext  = 1'b1;
      d.pair  = 3'(op - OP_SGN_FIRST);
    end else if (op >= OP_UNS_FIRST && op <= OP_UNS_LAST) begin
      d.legal = 1'b1;
      d.sext  = 1'b0;
      d.pair  = 3'(op - OP_UNS_FIRST);
    end
    return d;
  endfunction

  // Widen one element of sw bits (held right-aligned in raw) to 64 bits.
  function automatic logic [63:0] widen_elem(input logic [31:0] raw,
                                             input int unsigned sw,
                                             input logic sext);
    logic [63:0] keep;
    logic [63:0] res;
    keep = (64'd1 << sw) - 64'd1;
    res  = {32'd0, raw} & keep;
    if (sext && raw[sw-1]) res = res | ~keep;
    return res;
  endfunction

endpackage

// File: rtl/vwx_decode.sv
module vwx_decode
  import vwx_pkg::*;
(
  input  logic [4:0]           op_code,
  output logic                 legal,
  output logic                 sext,
  output logic [NUM_PAIRS-1:0] pair_hot
);

  vwx_dec_t dec;

  always_comb begin
    dec      = decode_op(op_code);
    legal    = dec.legal;
    sext     = dec.sext;
    pair_hot = '0;
    if (dec.legal) pair_hot[dec.pair] = 1'b1;
  end

  always_comb begin
    assert (legal ? $onehot(pair_hot) : (pair_hot == '0)) else $error("AST_PAIR_ONEHOT"); // R7
  end

endmodule

// File: rtl/vwx_lane_bank.sv
module vwx_lane_bank
  import vwx_pkg::*;
#(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned SRC_W = 8,
  parameter int unsigned DST_W = 16
) (
  input  logic [VLEN-1:0] src,
  input  logic            sext,
  output logic [VLEN-1:0] dst
);

  localparam int unsigned LANES = VLEN / DST_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SRC_W-1:0] elem;
    logic [63:0]      wide;
    assign elem = src[i*SRC_W +: SRC_W];
    assign wide = widen_elem(32'(elem), SRC_W, sext);
    assign dst[i*DST_W +: DST_W] = wide[DST_W-1:0];
  end

endmodule

// File: rtl/vwx_out_stage.sv
module vwx_out_stage #(
  parameter int unsigned VLEN      = 256,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VLEN-1:0] res_in,
  input  logic            ill_in,
  output logic            out_valid,
  output logic [VLEN-1:0] res_out,
  output logic            ill_out
);

  if (REGISTERED) begin : g_reg
    logic            vld_q;
    logic [VLEN-1:0] res_q;
    logic            ill_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        ill_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) begin
          res_q <= res_in;
          ill_q <= ill_in;
        end
      end
    end
    assign out_valid = vld_q;
    assign res_out   = res_q;
    assign ill_out   = ill_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign res_out   = res_in;
    assign ill_out   = ill_in;
  end

endmodule

// File: rtl/vec_widen_unit.sv
module vec_widen_unit
  import vwx_pkg::*;
#(
  parameter int unsigned VLEN       = 256,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4:0]      op_code,
  input  logic [VLEN-1:0] src_vec,
  output logic            out_valid,
  output logic [VLEN-1:0] dst_vec,
  output logic            op_illegal
);

  logic                 dec_legal;
  logic                 dec_sext;
  logic [NUM_PAIRS-1:0] dec_hot;
  logic [VLEN-1:0]      bank_res [NUM_PAIRS];
  logic [VLEN-1:0]      wide_res;

  vwx_decode u_dec (
    .op_code  (op_code),
    .legal    (dec_legal),
    .sext     (dec_sext),
    .pair_hot (dec_hot)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    vwx_lane_bank #(
      .VLEN  (VLEN),
      .SRC_W (pair_src_bits(p)),
      .DST_W (pair_dst_bits(p))
    ) u_bank (
      .src  (src_vec),
      .sext (dec_sext),
      .dst  (bank_res[p])
    );
  end

  // And-or select: an illegal opcode has no hot pair, so the result is zero.
  always_comb begin
    wide_res = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (dec_hot[p]) wide_res = wide_res | bank_res[p];
    end
  end

  vwx_out_stage #(
    .VLEN       (VLEN),
    .REGISTERED (REGISTERED)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .res_in    (wide_res),
    .ill_in    (~dec_legal),
    .out_valid (out_valid),
    .res_out   (dst_vec),
    .ill_out   (op_illegal)
  );

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_illegal) |-> (dst_vec == '0)); // R7

  if (REGISTERED) begin : g_chk
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dst_vec) && $stable(op_illegal))); // R9
    AST_FLAG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (op_illegal == ($past(op_code) < 5'd4 || $past(op_code) > 5'd15))); // R8
    AST_DB_SIGN_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code) == 5'd6) |->
      (dst_vec[63:0] == {{56{$past(src_vec[7])}}, $past(src_vec[7:0])})); // R4
    AST_DUWU_ZERO_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(op_code) == 5'd15) |->
      (dst_vec[63:0] == {32'd0, $past(src_vec[31:0])})); // R5
  end

endmodule

// File: tb/tb_vec_widen_unit.sv
module tb_vec_widen_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [4:0]   op_code;
  logic [255:0] src_vec;
  logic         out_valid;
  logic [255:0] dst_vec;
  logic         op_illegal;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  vec_widen_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_vec(src_vec), .out_valid(out_valid), .dst_vec(dst_vec),
    .op_illegal(op_illegal)
  );

  // Widths per opcode from R1/R2; zero widths mean illegal (R7).
  function automatic void op_widths(input logic [4:0] op, output int sw,
                                    output int dw, output bit sg);
    int k;
    sw = 0; dw = 0; sg = 0;
    if (op < 5'd4 || op > 5'd15) return;
    sg = (op <= 5'd9);
    k  = sg ? int'(op) - 4 : int'(op) - 10;
    sw = (k < 3) ? 8 : (k < 5) ? 16 : 32;
    dw = (k == 0) ? 16 : (k == 1 || k == 3) ? 32 : 64;
  endfunction

  function automatic logic [255:0] model(input logic [4:0] op,
                                         input logic [255:0] s);
    logic [255:0] r;
    logic [63:0]  e;
    logic [63:0]  m;
    int sw, dw;
    bit sg;
    r = '0;
    op_widths(op, sw, dw, sg);
    if (sw == 0) return r;
    m = (64'd1 << sw) - 64'd1;
    for (int i = 0; i < 256 / dw; i++) begin
      e = 64'(s >> (i * sw)) & m;
      if (sg && e[sw-1]) e = e | ~m;
      r = r | (256'(e & ((dw == 64) ? ~64'd0 : ((64'd1 << dw) - 64'd1))) << (i * dw));
    end
    return r;
  endfunction

  function automatic string req_of(input logic [4:0] op);
    if (op < 5'd4 || op > 5'd15) return "R7";
    if (op <= 5'd9) return "R1/R4";
    return "R2/R5";
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply one request and check it one clock later (R3, R8, R9 throughout).
  task automatic apply(input logic [4:0] op, input logic [255:0] s);
    logic [255:0] exp;
    bit           ill;
    exp = model(op, s);
    ill = (op < 5'd4 || op > 5'd15);
    @(negedge clk);
    op_code = op; src_vec = s; in_valid = 1'b1;
    @(posedge clk); #1;
    check(dst_vec == exp, req_of(op), $sformatf("R3 dst op=%0d", op), dst_vec, exp);
    check(op_illegal == ill, ill ? "R7" : "R8", $sformatf("flag op=%0d", op),
          256'(op_illegal), 256'(ill));
    check(out_valid == 1'b1, "R9", "valid after request", 256'(out_valid), 256'(1));
  endtask

  initial begin
    logic [255:0] pats [6];
    logic [255:0] held;
    logic [255:0] a;
    logic [255:0] b;
    logic         held_ill;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; src_vec = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1; op_code = 5'd6; src_vec = {32{8'h80}};
    @(posedge clk); #1;
    check(out_valid == 1'b0 && dst_vec == '0 && op_illegal == 1'b0, "R10",
          "reset state", dst_vec, '0);
    @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b0;

    pats[0] = {32{8'h80}};
    pats[1] = {32{8'h7F}};
    pats[2] = {16{16'h8000}};
    pats[3] = {8{32'h8000_0000}};
    pats[4] = '0;
    pats[5] = '1;

    for (int op = 0; op < 32; op++) begin
      for (int p = 0; p < 6; p++) apply(5'(op), pats[p]);
      for (int r = 0; r < 12; r++) apply(5'(op), rnd256());
    end

    // R1/R2 spot values: lane 0 of byte sign/zero extension to doubleword
    apply(5'd6, 256'h80);
    check(dst_vec[63:0] == 64'hFFFF_FFFF_FFFF_FF80, "R1", "op6 lane0",
          dst_vec, 256'hFFFF_FFFF_FFFF_FF80);
    apply(5'd12, 256'h80);
    check(dst_vec[63:0] == 64'h80, "R2", "op12 lane0", dst_vec, 256'h80);

    // R6: upper source elements ignored
    for (int op = 4; op < 16; op++) begin
      a = rnd256();
      b = a;
      b[255:128] = ~a[255:128];
      apply(5'(op), a);
      held = dst_vec;
      apply(5'(op), b);
      check(dst_vec == held, "R6", $sformatf("upper ignored op=%0d", op), dst_vec, held);
    end

    // R9: idle cycle holds output and drops valid
    apply(5'd20, rnd256());
    apply(5'd9, {8{32'h8000_0000}});
    held = dst_vec; held_ill = op_illegal;
    @(negedge clk);
    in_valid = 1'b0; op_code = 5'd0; src_vec = rnd256();
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R9", "idle valid", 256'(out_valid), 256'(0));
    check(dst_vec == held && op_illegal == held_ill, "R9", "idle hold", dst_vec, held);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule